// File: doc/BRIEF.md
# Five-Channel DAC Command Loader

This block takes 16-bit command frames from a serial link and turns them into updates of five 12-bit converter codes. The serial clock, data line and active-low select all arrive from outside the system clock domain. Each passes through a two-flop synchronizer. After that, the serial clock is edge-detected in the system clock domain. A shift register collects the data bits, most significant bit first. A saturating counter tracks how many bits have arrived.

A frame is accepted only when the select line rises after exactly sixteen serial clock edges. The top three bits of the frame name the destination channel. The low twelve bits are the code, and the bit between them is ignored. The chosen holding register loads the code, and that channel's update strobe is high for one system clock cycle. A channel field that names no existing channel leaves every register unchanged and sets an error flag. The flag stays set until reset.

Each serial clock phase must last at least three system clock cycles. Between frames, the select line must stay high for at least three system clock cycles. With a 125 MHz system clock, this supports a 20 MHz serial clock and frames sent back to back.

Top module: `dac_cmd_loader`

## Requirements
- R1: After reset, all five channel values are 0, every update strobe is 0 and the error flag is 0.
- R2: Data is sampled on each rising serial clock edge while select is low, most significant bit first. When select rises after exactly 16 such edges, frame bits [11:0] become the addressed channel's value.
- R3: Frame bits [15:13] hold the channel field: codes 0, 1, 2, 3 and 4 select channels 0, 1, 2, 3 and 4.
- R4: Frame bit 12 has no effect on which channel is written or on the value written.
- R5: A frame with any bit count other than 16 (including 0, 15 and 17) changes no channel value and raises no strobe.
- R6: Channel codes 5, 6 and 7 change no channel value and raise no strobe. They set the error flag, which stays 1 until reset.
- R7: Each accepted frame pulses exactly one update strobe, the one for the addressed channel, for exactly one system clock cycle. The strobe is high in the same cycle in which the new value first appears. A channel value never changes without its strobe.
- R8: Two frames separated by select high for three system clock cycles are both accepted, in order.
- R9: Serial clock edges while select is high shift no data and change no output.
- R10: Asserting reset at any time returns all outputs to the state given in R1, including clearing a set error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| sdi | input | 1 | Serial data, sampled on rising sclk |
| cs_n | input | 1 | Active-low frame select |
| ch_value | output | 5 x 12 | Channel holding registers, channel i at bits [12*i+11:12*i] |
| ch_strobe | output | 5 | One-cycle update strobe, bit i for channel i |
| addr_err | output | 1 | Sticky flag for a frame with channel code 5 to 7 |

## Verification
Frames of 15 and 17 bits are sent. A counter that checked only for at least sixteen bits, or that wrapped, would accept the 17-bit frame and load a shifted code. Codes that differ only in bit 12 are sent to the same channel. A decoder that took four bits of address would then write the wrong channel or lose the update. Invalid codes 5 and 7 are sent, each followed by valid frames, to expose a flag that clears itself or a decode that wraps an invalid code into a real channel. Serial clock activity with select high, back-to-back frames, and a reset in the middle of the run are also covered. These catch, in turn, a shifter that ignores select, an edge detector that misses the short gap between frames, and a flag that survives reset.

// File: rtl/dac_cmd_pkg.sv
`timescale 1ns/1ps
package dac_cmd_pkg;
    localparam int DEF_NCH     = 5;
    localparam int DEF_CODE_W  = 12;
    localparam int DEF_FRAME_W = 16;
    localparam int DEF_ADDR_W  = 3;
endpackage

// File: rtl/dac_sync.sv
`timescale 1ns/1ps
module dac_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = async_in;
        s_d.sync = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{meta: RST_VAL, sync: RST_VAL};
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_out = s_q.sync;
endmodule

// File: rtl/dac_frame_rx.sv
`timescale 1ns/1ps
module dac_frame_rx #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               cs_s,
    input  logic               sdi_s,
    output logic               frame_valid,
    output logic [FRAME_W-1:0] frame_word
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
        logic               sclk_p;
        logic               cs_p;
        logic               vld;
        logic [FRAME_W-1:0] word;
    } rx_t;

    rx_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.vld    = 1'b0;
        r_d.sclk_p = sclk_s;
        r_d.cs_p   = cs_s;
        if (cs_s) begin
            // select inactive: close a frame on its rising edge, hold count at zero
            if (!r_q.cs_p && (r_q.cnt == CNT_FULL)) begin
                r_d.vld  = 1'b1;
                r_d.word = r_q.shreg;
            end
            r_d.cnt = '0;
        end else if (sclk_s && !r_q.sclk_p) begin
            r_d.shreg = {r_q.shreg[FRAME_W-2:0], sdi_s};
            if (r_q.cnt != CNT_OVER) begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{shreg: '0, cnt: '0, sclk_p: 1'b0, cs_p: 1'b1, vld: 1'b0, word: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign frame_valid = r_q.vld;
    assign frame_word  = r_q.word;
endmodule

// File: rtl/dac_chan_regs.sv
`timescale 1ns/1ps
module dac_chan_regs #(
    parameter int NCH     = 5,
    parameter int CODE_W  = 12,
    parameter int FRAME_W = 16,
    parameter int ADDR_W  = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_valid,
    input  logic [FRAME_W-1:0]           frame_word,
    output logic [NCH-1:0][CODE_W-1:0]   ch_value,
    output logic [NCH-1:0]               ch_strobe,
    output logic                         addr_err
);
    typedef struct packed {
        logic [NCH-1:0][CODE_W-1:0] val;
        logic [NCH-1:0]             stb;
        logic                       err;
    } regs_t;

    regs_t g_d, g_q;
    logic [ADDR_W-1:0] addr;
    logic              hit;

    assign addr = frame_word[FRAME_W-1 -: ADDR_W];

    always_comb begin
        g_d     = g_q;
        g_d.stb = '0;
        hit     = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (frame_valid && (int'(addr) == i)) begin
                g_d.val[i] = frame_word[CODE_W-1:0];
                g_d.stb[i] = 1'b1;
                hit        = 1'b1;
            end
        end
        if (frame_valid && !hit) begin
            g_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign ch_value  = g_q.val;
    assign ch_strobe = g_q.stb;
    assign addr_err  = g_q.err;
endmodule

// File: rtl/dac_cmd_loader.sv
`timescale 1ns/1ps
module dac_cmd_loader
    import dac_cmd_pkg::*;
#(
    parameter int NCH     = DEF_NCH,
    parameter int CODE_W  = DEF_CODE_W,
    parameter int FRAME_W = DEF_FRAME_W,
    parameter int ADDR_W  = DEF_ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk,
    input  logic                       sdi,
    input  logic                       cs_n,
    output logic [NCH-1:0][CODE_W-1:0] ch_value,
    output logic [NCH-1:0]             ch_strobe,
    output logic                       addr_err
);
    logic [2:0]         pins_s;
    logic               sclk_s, cs_s, sdi_s;
    logic               frame_valid;
    logic [FRAME_W-1:0] frame_word;

    dac_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sclk, cs_n, sdi}),
        .sync_out (pins_s)
    );

    assign sclk_s = pins_s[2];
    assign cs_s   = pins_s[1];
    assign sdi_s  = pins_s[0];

    dac_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (sclk_s),
        .cs_s        (cs_s),
        .sdi_s       (sdi_s),
        .frame_valid (frame_valid),
        .frame_word  (frame_word)
    );

    dac_chan_regs #(
        .NCH(NCH), .CODE_W(CODE_W), .FRAME_W(FRAME_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .frame_word  (frame_word),
        .ch_value    (ch_value),
        .ch_strobe   (ch_strobe),
        .addr_err    (addr_err)
    );
endmodule

// File: rtl/dac_cmd_checker.sv
`timescale 1ns/1ps
module dac_cmd_checker #(
    parameter int NCH     = 5,
    parameter int CODE_W  = 12,
    parameter int FRAME_W = 16,
    parameter int ADDR_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0][CODE_W-1:0] ch_value,
    input  logic [NCH-1:0]             ch_strobe,
    input  logic                       addr_err,
    input  logic                       frame_valid,
    input  logic [FRAME_W-1:0]         frame_word,
    input  logic                       cs_s
);
    // R7: at most one strobe per cycle
    p_onehot_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_strobe));

    // R7: a strobe is always caused by a completed frame in the previous cycle
    p_strobe_after_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_strobe != '0) |-> $past(frame_valid));

    // R6: error flag never clears without reset
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> addr_err);

    // R6: an out-of-range channel field produces no strobe
    p_bad_addr_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && (int'(frame_word[FRAME_W-1 -: ADDR_W]) >= NCH)) |=> (ch_strobe == '0 && addr_err));

    // R2, R5: a frame only completes while select is inactive
    p_frame_on_cs_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> cs_s);

    // R7: a value only changes together with its strobe
    for (genvar i = 0; i < NCH; i++) begin : g_val
        p_value_needs_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_value[i] != $past(ch_value[i])) |-> ch_strobe[i]);
    end
endmodule

bind dac_cmd_loader dac_cmd_checker #(
    .NCH(NCH), .CODE_W(CODE_W), .FRAME_W(FRAME_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_value    (ch_value),
    .ch_strobe   (ch_strobe),
    .addr_err    (addr_err),
    .frame_valid (frame_valid),
    .frame_word  (frame_word),
    .cs_s        (cs_s)
);

// File: tb/tb_dac_cmd_loader.sv
`timescale 1ns/1ps
module tb_dac_cmd_loader;
    localparam int NCH = 5;
    localparam int CW  = 12;
    localparam int NV  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic cs_n = 1'b1;
    logic [NCH-1:0][CW-1:0] ch_value;
    logic [NCH-1:0]         ch_strobe;
    logic                   addr_err;

    int n_checks = 0;
    int n_fail   = 0;
    int stb_cnt [NCH];
    int multi_cnt = 0;
    int wide_cnt  = 0;
    logic [NCH-1:0] stb_prev = '0;

    logic [CW-1:0] exp_val [NCH];
    int            exp_stb [NCH];
    logic          exp_err;

    // stimulus table: pattern (sent MSB first over nbits), bit count
    localparam logic [16:0] VP [NV] = '{
        17'h00ABC, 17'h03123, 17'h04FFF, 17'h07001, 17'h08800,
        17'h02555, 17'h00EEF, 17'h0A123, 17'h01FFF, 17'h0E000 };
    localparam int VN [NV] = '{16, 16, 16, 16, 16, 15, 17, 16, 16, 16};

    always #4 clk = ~clk;

    dac_cmd_loader dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .ch_value(ch_value), .ch_strobe(ch_strobe), .addr_err(addr_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                if (ch_strobe[i]) stb_cnt[i]++;
                if (ch_strobe[i] && stb_prev[i]) wide_cnt++;
            end
            if ($countones(ch_strobe) > 1) multi_cnt++;
        end
        stb_prev = ch_strobe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [16:0] pat, input int nbits, input int gap_ns);
        cs_n = 1'b0;
        #25;
        for (int b = nbits - 1; b >= 0; b--) begin
            sdi = pat[b];
            #25 sclk = 1'b1;
            #25 sclk = 1'b0;
        end
        #25 cs_n = 1'b1;
        #(gap_ns);
    endtask

    task automatic model(input logic [16:0] pat, input int nbits);
        int a;
        if (nbits == 16) begin
            a = int'(pat[15:13]);
            if (a < NCH) begin
                exp_val[a] = pat[11:0];
                exp_stb[a]++;
            end else begin
                exp_err = 1'b1;
            end
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NCH; i++) begin
            check(ch_value[i] == exp_val[i], req, int'(ch_value[i]), int'(exp_val[i]));
            check(stb_cnt[i] == exp_stb[i], {req, " R7 strobe count"}, stb_cnt[i], exp_stb[i]);
        end
        check(addr_err == exp_err, {req, " err"}, int'(addr_err), int'(exp_err));
    endtask

    task automatic clear_model();
        for (int i = 0; i < NCH; i++) begin
            exp_val[i] = '0; exp_stb[i] = 0; stb_cnt[i] = 0;
        end
        exp_err = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        clear_model();
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check_all("R1 reset");
        check(ch_strobe == '0, "R1 strobe", int'(ch_strobe), 0);

        // table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            send(VP[v], VN[v], 120);
            model(VP[v], VN[v]);
            @(negedge clk);
            check_all($sformatf("R2 R3 R4 R5 R6 vector %0d", v));
        end

        // R5: select pulse with no bits
        cs_n = 1'b0; #100 cs_n = 1'b1; #120;
        @(negedge clk);
        check_all("R5 zero-bit frame");

        // R9: serial clock with select high does nothing
        for (int k = 0; k < 20; k++) begin
            sdi = k[0];
            #25 sclk = 1'b1;
            #25 sclk = 1'b0;
        end
        #120;
        @(negedge clk);
        check_all("R9 sclk while deselected");

        // R9: stray edges before a frame do not corrupt it
        send(17'h04321, 16, 120);
        model(17'h04321, 16);
        @(negedge clk);
        check_all("R9 frame after stray clocks");

        // R8: back-to-back frames, select high 25 ns between them
        send(17'h05AAA, 16, 25);
        send(17'h09555, 16, 25);
        send(17'h05BBB, 16, 120);
        model(17'h05AAA, 16);
        model(17'h09555, 16);
        model(17'h05BBB, 16);
        @(negedge clk);
        check_all("R8 back-to-back");

        // R7: strobe shape over the whole run
        check(multi_cnt == 0, "R7 multiple strobes", multi_cnt, 0);
        check(wide_cnt == 0, "R7 strobe width", wide_cnt, 0);

        // R10: reset mid-run clears values and sticky error
        check(addr_err == 1'b1, "R6 err before reset", int'(addr_err), 1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        clear_model();
        check_all("R10 during reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R10 after reset");

        // R3: valid frame after reset works again
        send(17'h08007, 16, 120);
        model(17'h08007, 16);
        @(negedge clk);
        check_all("R3 after reset");

        summary();
    end
endmodule